// File: doc/BRIEF.md
# Interrupt Source Mapper and Single-Request Arbiter

This block gathers sixty-four level-sensitive interrupt lines into one outstanding vector request. Lines 0 to 31 come from expansion-bus slots. Lines 32 to 63 come from on-board peripherals. Each slot line belongs to a group of four, and one mapping register with an enable bit covers each group. Each on-board line has its own mapping register. Software reaches the mapping registers and a set of clear registers through a 32-bit word-addressed port. Writes take effect at the clock edge. Reads are combinational.

Only one request is outstanding at any time. It appears as a 7-bit request number and as one hot line out of sixty-four vector outputs. It stays up until one of two things happens: software writes the matching clear register, or software disables the mapping of the pending line. A separate combinational helper turns a slot device/function number and an interrupt pin into the slot line number that the device drives.

Word address layout: bits 7:6 select the region (00 slot maps, 01 on-board maps, 10 slot clears, 11 on-board clears). Bits 5:1 hold the register index, and bit 0 must be 1 for the access to take effect. In the slot regions only indices 0 to 7 exist.

Top module: `irqmap_arbiter`

## Requirements
- R1: After `rst`, the slot map register of index i reads 0x7C0 | (i<<2) and the on-board map register of index j reads 0x7E0 + j. Every enable (bit 31) is zero, `req_id` is 65 and no vector output is high.
- R2: A write to a map register changes only bit 31. Bits 30:0 keep their reset values. A read with address bit 0 cleared returns zero.
- R3: Any map write triggers arbitration when no request is pending. Arbitration picks the lowest-numbered line that was high in the previous cycle and whose map is enabled. Slot lines 0–31 come before on-board lines 32–63. The new request shows after that clock edge.
- R4: A rising edge on a slot line whose group map is enabled makes that line the request after the next edge, and it replaces any pending request. When several such lines rise together, the lowest-numbered one wins.
- R5: A rising edge on an on-board line with its map enabled becomes the request only if nothing is pending. Otherwise it has no effect on the request. A rising edge on any disabled line has no effect.
- R6: A pending request stays unchanged while no clear, no cancel and no enabled slot edge occurs. A map write made while a request is pending keeps that same request. A line falling leaves the request in place.
- R7: A map write with bit 31 cleared cancels the pending request when it covers the pending line: a slot group when the pending number divided by 4 equals the index, an on-board map when the pending number equals 32 + index. The block then re-arbitrates.
- R8: A write to slot clear register k clears the pending request only when the pending number divided by 4 equals k. After clearing, the block re-arbitrates. Otherwise the write has no effect.
- R9: A write to on-board clear register j clears the pending request only when the pending number is exactly 32 + j. After clearing, the block re-arbitrates.
- R10: `bus_rst` clears every enable bit, the pending request and the record of input levels. Bits 30:0 of the map registers keep their values.
- R11: `pin_line` equals (16 if `pin_devfn` bit 0 is set, else 0) + 4 × `pin_devfn[7:3]` + `pin_num`, taken modulo 32.
- R12: `vec_req` has exactly one bit set, at position `req_id`, when a request is pending. When `req_id` is 65 (none), `vec_req` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_rst | input | 1 | Synchronous active-high bus reset |
| src_lvl | input | 64 | Interrupt line levels, slot lines 0–31, on-board lines 32–63 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pin_devfn | input | 8 | Slot device (bits 7:3) and function (bits 2:0) |
| pin_num | input | 2 | Interrupt pin of that device, 0–3 |
| pin_line | output | 5 | Slot line number driven by that pin |
| req_id | output | 7 | Pending request number, 65 when none |
| vec_req | output | 64 | One-hot vector request outputs |

## Verification
The bench builds the block with its default counts: eight slot groups of four lines and thirty-two on-board lines. With these counts the bench can reach the group-of-four clear rule with a non-matching index, and it can test slot preemption against a pending on-board request. It also covers the handoff from one pending on-board line to the next, line 40 to 41, through exact-match clears and through cancelling by disable. Simultaneous edges on lines 1 and 2 check lowest-number priority, and a bus reset with lines still high checks that fresh edges from disabled lines are dropped.

// File: rtl/irqmap_pkg.sv
`timescale 1ns/1ps
package irqmap_pkg;

    localparam int PCI_GRPS = 8;
    localparam int GRP_SZ   = 4;
    localparam int OB_SRCS  = 32;
    localparam int PCI_SRCS = PCI_GRPS * GRP_SZ;
    localparam int NSRC     = PCI_SRCS + OB_SRCS;
    localparam int ID_W     = $clog2(NSRC + 2);
    localparam int ADDR_W   = 8;
    localparam int IDX_W    = 5;
    localparam int GRP_W    = $clog2(PCI_GRPS);

    localparam logic [ID_W-1:0] NONE_ID = ID_W'(NSRC + 1);

    typedef enum logic [1:0] {
        RG_PCI_MAP = 2'b00,
        RG_OB_MAP  = 2'b01,
        RG_PCI_CLR = 2'b10,
        RG_OB_CLR  = 2'b11
    } region_e;

    typedef struct packed {
        logic             hit;
        region_e          region;
        logic [IDX_W-1:0] idx;
        logic             en;
    } reg_op_t;

    function automatic logic [31:0] pci_map_base(input logic [IDX_W-1:0] i);
        return 32'h7C0 | {25'd0, i, 2'b00};
    endfunction

    function automatic logic [31:0] ob_map_base(input logic [IDX_W-1:0] i);
        return 32'h7E0 + {27'd0, i};
    endfunction

    function automatic logic [ID_W-1:0] first_set(input logic [NSRC-1:0] v);
        logic [ID_W-1:0] r;
        r = NONE_ID;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = ID_W'(i);
        end
        return r;
    endfunction

    function automatic logic [4:0] pci_line(input logic [4:0] slot,
                                            input logic       fn0,
                                            input logic [1:0] pin);
        logic [6:0] s;
        s = (fn0 ? 7'd16 : 7'd0) + {slot, 2'b00} + {5'd0, pin};
        return s[4:0];
    endfunction

endpackage

// File: rtl/intmap_regs.sv
`timescale 1ns/1ps
module intmap_regs
    import irqmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wbit,
    output logic [31:0]         rdata,
    output reg_op_t             op,
    output logic [PCI_GRPS-1:0] pci_en_q,
    output logic [OB_SRCS-1:0]  ob_en_q,
    output logic [PCI_GRPS-1:0] pci_en_nx,
    output logic [OB_SRCS-1:0]  ob_en_nx
);

    region_e          region;
    logic [IDX_W-1:0] idx;
    logic             odd;
    logic             idx_ok;
    logic [31:0]      base;

    assign region = region_e'(addr[ADDR_W-1:ADDR_W-2]);
    assign idx    = addr[IDX_W:1];
    assign odd    = addr[0];
    // on-board regions have region bit 0 set and use the full index range
    assign idx_ok = region[0] ? 1'b1 : (idx < IDX_W'(PCI_GRPS));

    assign op.hit    = we && odd && idx_ok;
    assign op.region = region;
    assign op.idx    = idx;
    assign op.en     = wbit;

    always_comb begin
        pci_en_nx = pci_en_q;
        ob_en_nx  = ob_en_q;
        if (op.hit && op.region == RG_PCI_MAP) pci_en_nx[op.idx[GRP_W-1:0]] = op.en;
        if (op.hit && op.region == RG_OB_MAP)  ob_en_nx[op.idx] = op.en;
    end

    always_ff @(posedge clk) begin
        if (rst || bus_rst) begin
            pci_en_q <= '0;
            ob_en_q  <= '0;
        end else begin
            pci_en_q <= pci_en_nx;
            ob_en_q  <= ob_en_nx;
        end
    end

    always_comb begin
        rdata = '0;
        base  = '0;
        if (odd && idx_ok) begin
            unique case (region)
                RG_PCI_MAP: begin
                    base  = pci_map_base(idx);
                    rdata = {pci_en_q[idx[GRP_W-1:0]], base[30:0]};
                end
                RG_OB_MAP: begin
                    base  = ob_map_base(idx);
                    rdata = {ob_en_q[idx], base[30:0]};
                end
                RG_PCI_CLR, RG_OB_CLR: rdata = '0;
            endcase
        end
    end

    // R10
    bus_rst_clears_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> (pci_en_q == '0 && ob_en_q == '0));

    // R2
    map_write_lands_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
        (op.hit && op.region == RG_OB_MAP) |=> (ob_en_q[$past(op.idx)] == $past(op.en)));

endmodule

// File: rtl/intmap_arb.sv
`timescale 1ns/1ps
module intmap_arb
    import irqmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_rst,
    input  logic [NSRC-1:0]     src,
    input  reg_op_t             op,
    input  logic [PCI_GRPS-1:0] pci_en_q,
    input  logic [OB_SRCS-1:0]  ob_en_q,
    input  logic [PCI_GRPS-1:0] pci_en_nx,
    input  logic [OB_SRCS-1:0]  ob_en_nx,
    output logic [ID_W-1:0]     req_id
);

    localparam logic [NSRC-1:0] PCI_MASK = {{OB_SRCS{1'b0}}, {PCI_SRCS{1'b1}}};

    logic [NSRC-1:0] lvl_q, en_nx_mask, en_q_mask, rise, pci_hit, ob_hit;
    logic [ID_W-1:0] req_q, req_nx, cur;
    logic            rearb, grp_match, ob_match;

    for (genvar g = 0; g < NSRC; g++) begin : g_mask
        if (g < PCI_SRCS) begin : g_pci
            assign en_nx_mask[g] = pci_en_nx[g / GRP_SZ];
            assign en_q_mask[g]  = pci_en_q[g / GRP_SZ];
        end else begin : g_ob
            assign en_nx_mask[g] = ob_en_nx[g - PCI_SRCS];
            assign en_q_mask[g]  = ob_en_q[g - PCI_SRCS];
        end
    end

    assign rise    = src & ~lvl_q;
    assign pci_hit = rise & en_nx_mask & PCI_MASK;
    assign ob_hit  = rise & en_nx_mask & ~PCI_MASK;

    assign grp_match = (req_q < ID_W'(PCI_SRCS)) &&
                       (req_q[GRP_W+1:2] == op.idx[GRP_W-1:0]);
    assign ob_match  = (req_q >= ID_W'(PCI_SRCS)) && (req_q < ID_W'(NSRC)) &&
                       (req_q[IDX_W-1:0] == op.idx);

    always_comb begin
        cur   = req_q;
        rearb = 1'b0;
        if (op.hit) begin
            unique case (op.region)
                RG_PCI_MAP: begin
                    rearb = 1'b1;
                    if (!op.en && grp_match) cur = NONE_ID;
                end
                RG_OB_MAP: begin
                    rearb = 1'b1;
                    if (!op.en && ob_match) cur = NONE_ID;
                end
                RG_PCI_CLR: if (grp_match) begin
                    cur   = NONE_ID;
                    rearb = 1'b1;
                end
                RG_OB_CLR: if (ob_match) begin
                    cur   = NONE_ID;
                    rearb = 1'b1;
                end
            endcase
        end
        if (rearb && cur == NONE_ID) cur = first_set(lvl_q & en_nx_mask);
        if (|pci_hit)                            cur = first_set(pci_hit);
        else if (cur == NONE_ID && (|ob_hit))    cur = first_set(ob_hit);
        req_nx = cur;
    end

    always_ff @(posedge clk) begin
        if (rst || bus_rst) begin
            req_q <= NONE_ID;
            lvl_q <= '0;
        end else begin
            req_q <= req_nx;
            lvl_q <= src;
        end
    end

    assign req_id = req_q;

    // R6
    pending_hold_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
        (req_q != NONE_ID && !op.hit && !(|pci_hit)) |=> (req_q == $past(req_q)));

    // R3
    pick_enabled_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
        (req_nx != req_q && req_nx != NONE_ID) |=> en_q_mask[req_q[IDX_W:0]]);

endmodule

// File: rtl/intmap_pinmap.sv
`timescale 1ns/1ps
module intmap_pinmap
    import irqmap_pkg::*;
(
    input  logic [7:0] devfn,
    input  logic [1:0] pin,
    output logic [4:0] line
);

    logic unused_fn_bits;
    assign unused_fn_bits = ^devfn[2:1];

    assign line = pci_line(devfn[7:3], devfn[0], pin);

endmodule

// File: rtl/irqmap_arbiter.sv
`timescale 1ns/1ps
module irqmap_arbiter
    import irqmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst,
    input  logic [NSRC-1:0]   src_lvl,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [7:0]        pin_devfn,
    input  logic [1:0]        pin_num,
    output logic [4:0]        pin_line,
    output logic [ID_W-1:0]   req_id,
    output logic [NSRC-1:0]   vec_req
);

    reg_op_t             op;
    logic [PCI_GRPS-1:0] pci_en_q, pci_en_nx;
    logic [OB_SRCS-1:0]  ob_en_q, ob_en_nx;
    logic                unused_wdata;

    assign unused_wdata = ^reg_wdata[30:0];

    intmap_regs u_regs (
        .clk(clk), .rst(rst), .bus_rst(bus_rst),
        .we(reg_we), .addr(reg_addr), .wbit(reg_wdata[31]),
        .rdata(reg_rdata), .op(op),
        .pci_en_q(pci_en_q), .ob_en_q(ob_en_q),
        .pci_en_nx(pci_en_nx), .ob_en_nx(ob_en_nx)
    );

    intmap_arb u_arb (
        .clk(clk), .rst(rst), .bus_rst(bus_rst),
        .src(src_lvl), .op(op),
        .pci_en_q(pci_en_q), .ob_en_q(ob_en_q),
        .pci_en_nx(pci_en_nx), .ob_en_nx(ob_en_nx),
        .req_id(req_id)
    );

    intmap_pinmap u_pin (
        .devfn(pin_devfn), .pin(pin_num), .line(pin_line)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_vec
        assign vec_req[g] = (req_id == ID_W'(g));
    end

    // R12
    vec_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(vec_req) && ((req_id == NONE_ID) == (vec_req == '0)));

    // R12
    id_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (req_id < ID_W'(NSRC)) || (req_id == NONE_ID));

endmodule

// File: tb/irqmap_arbiter_tb.sv
`timescale 1ns/1ps
module irqmap_arbiter_tb;
    import irqmap_pkg::*;

    logic              clk = 1'b0;
    logic              rst, bus_rst, reg_we;
    logic [NSRC-1:0]   src_lvl;
    logic [ADDR_W-1:0] reg_addr;
    logic [31:0]       reg_wdata, reg_rdata;
    logic [7:0]        pin_devfn;
    logic [1:0]        pin_num;
    logic [4:0]        pin_line;
    logic [ID_W-1:0]   req_id;
    logic [NSRC-1:0]   vec_req;

    always #2.5 clk = ~clk;

    irqmap_arbiter u_dut (
        .clk(clk), .rst(rst), .bus_rst(bus_rst), .src_lvl(src_lvl),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pin_devfn(pin_devfn), .pin_num(pin_num),
        .pin_line(pin_line), .req_id(req_id), .vec_req(vec_req)
    );

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    item_t cur_it;
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    logic [NSRC-1:0] exp_vec;

    // monitor: compare every queued expectation at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            cur_it = q.pop_front();
            checks++;
            case (cur_it.kind)
                0: begin
                    exp_vec = (cur_it.exp == 32'd65) ? '0 : (64'd1 << cur_it.exp);
                    if (req_id !== cur_it.exp[ID_W-1:0] || vec_req !== exp_vec) begin
                        fails++;
                        $display("FAIL %s req_id=%0d vec=%h expected id=%0d vec=%h",
                                 cur_it.tag, req_id, vec_req, cur_it.exp, exp_vec);
                    end
                end
                1: if (reg_rdata !== cur_it.exp) begin
                    fails++;
                    $display("FAIL %s rdata=%h expected=%h", cur_it.tag, reg_rdata, cur_it.exp);
                end
                default: if (pin_line !== cur_it.exp[4:0]) begin
                    fails++;
                    $display("FAIL %s line=%0d expected=%0d", cur_it.tag, pin_line, cur_it.exp);
                end
            endcase
        end
    end

    task automatic push(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic exp_req(int id, string tag);
        push(0, 32'(id), tag);
        settle();
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        push(1, exp, tag);
        settle();
    endtask

    task automatic set_src(int i, logic v);
        src_lvl[i] = v;
        @(posedge clk);
        #1;
    endtask

    task automatic pin_chk(logic [7:0] df, logic [1:0] p, int exp, string tag);
        pin_devfn = df;
        pin_num   = p;
        push(2, 32'(exp), tag);
        settle();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_rst = 1'b0; reg_we = 1'b0; src_lvl = '0;
        reg_addr = '0; reg_wdata = '0; pin_devfn = '0; pin_num = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        settle();

        // reset state
        exp_req(65, "R1 R12 no request after reset");
        rd_chk(8'h07, 32'h0000_07CC, "R1 slot map 3 reset value");
        rd_chk(8'h4B, 32'h0000_07E5, "R1 on-board map 5 reset value");
        rd_chk(8'h06, 32'h0,         "R2 even offset reads zero");

        // device pin to line mapping
        pin_chk(8'h19, 2'd2, 30, "R11 slot3 fn1 pin2");
        pin_chk(8'h38, 2'd3, 31, "R11 slot7 fn0 pin3");
        pin_chk(8'h39, 2'd1, 13, "R11 slot7 fn1 pin1 wraps");

        // enable slot group 3: only bit 31 sticks
        wr(8'h07, 32'hFFFF_FFFF);
        exp_req(65, "R3 no asserted line to pick");
        rd_chk(8'h07, 32'h8000_07CC, "R2 only enable bit written");

        // disabled on-board edge, then enabling map arbitrates
        set_src(40, 1'b1);
        exp_req(65, "R5 edge on disabled line ignored");
        wr(8'h51, 32'h8000_0000);
        exp_req(40, "R3 map write picks line 40");

        // slot edge preempts
        set_src(13, 1'b1);
        exp_req(13, "R4 slot edge replaces pending");

        // map write while pending re-asserts, on-board edge ignored
        wr(8'h53, 32'h8000_0000);
        exp_req(13, "R6 map write keeps pending");
        set_src(41, 1'b1);
        exp_req(13, "R5 on-board edge ignored while pending");

        // slot clears
        wr(8'h85, 32'h0);
        exp_req(13, "R8 clear of other group no effect");
        set_src(13, 1'b0);
        exp_req(13, "R6 falling line keeps request");
        wr(8'h87, 32'h0);
        exp_req(40, "R8 group clear then lowest enabled line");

        // on-board clears
        wr(8'hD3, 32'h0);
        exp_req(40, "R9 clear of other line no effect");
        set_src(40, 1'b0);
        exp_req(40, "R6 pending held after line drop");
        wr(8'hD1, 32'h0);
        exp_req(41, "R9 exact clear then next line");

        // cancel by disabling
        set_src(40, 1'b1);
        exp_req(41, "R5 on-board edge ignored while pending");
        wr(8'h53, 32'h0);
        exp_req(40, "R7 disable cancels and rearbitrates");
        wr(8'h51, 32'h0);
        exp_req(65, "R7 disable cancels with nothing left");

        // on-board edge with nothing pending
        wr(8'h69, 32'h8000_0000);
        exp_req(65, "R3 nothing asserted on enabled maps");
        set_src(52, 1'b1);
        exp_req(52, "R5 on-board edge raises when idle");

        // slot priority among simultaneous edges
        wr(8'h01, 32'h8000_0000);
        exp_req(52, "R6 map write keeps pending");
        src_lvl[1] = 1'b1;
        src_lvl[2] = 1'b1;
        @(posedge clk);
        #1;
        exp_req(1, "R4 lowest simultaneous slot edge wins");

        // bus reset
        bus_rst = 1'b1;
        @(posedge clk);
        #1 bus_rst = 1'b0;
        exp_req(65, "R10 bus reset drops request");
        rd_chk(8'h07, 32'h0000_07CC, "R10 slot map enable cleared");
        rd_chk(8'h69, 32'h0000_07F4, "R10 on-board map enable cleared");
        exp_req(65, "R10 edges on disabled lines after bus reset");

        // enable-only writes on slot group 0
        wr(8'h01, 32'h7FFF_FFFF);
        exp_req(65, "R2 write with enable clear");
        rd_chk(8'h01, 32'h0000_07C0, "R2 low bits unchanged");
        wr(8'h01, 32'h8000_0000);
        exp_req(1, "R3 rearbitration picks line 1");
        rd_chk(8'h01, 32'h8000_07C0, "R2 enable set low bits kept");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule